// File: doc/BRIEF.md
# Dual-Path Service Register Bank

This block holds a small bank of 64-bit service registers that can be reached over two routes. One route is a scan/configuration path that names each register by its index directly. The other is a memory-mapped window whose word index is moved up by a fixed offset, so word 0 of the window lands on the base-address register. Both routes share one request channel. A select bit says which route the current request came from.

Every access moves a full 64-bit word. Some indices are not storage but aliases: writing to them sets or clears bits in a shared register. Several registers keep only some bit fields of the written value. The base-address register can be written only from the scan route. The interrupt status word is read-only and mirrors an input vector. Illegal writes raise a one-cycle error pulse. Read data is registered and appears one cycle after the request. The enable bit and address field of the base register are exported, together with a window-hit compare against a probe address, so downstream decode can claim accesses to the window.

Top module: `svc_regbank`

## Requirements
- R1: A scan request addresses register index `req_index`. A memory-mapped request addresses index `req_index + 0x0A`. A memory-mapped index that lands past 0x1F is treated as unimplemented.
- R2: Index 0x00 is a full 64-bit fault register. A write to index 0x01 replaces it with (fault AND data). A write to index 0x02 replaces it with (fault OR data).
- R3: Index 0x0E is a full 64-bit control register. A write to 0x12 ORs the data into it. A write to 0x13 clears the bits that are set in the data.
- R4: Index 0x0A, the base register, keeps only data bits 49:20 and bit 0 (enable). A scan write updates it. A memory-mapped write leaves it unchanged and raises the error pulse.
- R5: Index 0x0B keeps only data bits 49:32; all other bits read as zero.
- R6: Index 0x15 reads the `stat_in` vector. A write to it changes nothing and raises the error pulse.
- R7: A read of any index that has no readable register returns all ones. This covers the alias indices 0x01, 0x02, 0x12 and 0x13. A write to an unimplemented index has no effect and raises no error.
- R8: After reset the base register holds `RST_BASE` bits 49:20 with the enable bit set. Every other stored register is zero, and `rd_valid` and `wr_err` are low.
- R9: A read request gives `rd_valid` high with `rd_data` one cycle later. `wr_err` is a single-cycle pulse in the cycle after an illegal write, and it stays low after any other request.
- R10: `win_hit` is high exactly when the enable bit is set and `probe_addr[49:20]` equals the base field. `win_en` and `win_base` export that bit and that field.
- R11: Indices 0x06, 0x07, 0x0F and 0x14 are plain 64-bit read/write registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mmio | input | 1 | 1 = memory-mapped route, 0 = scan route |
| req_index | input | IDX_W | Word index on the selected route |
| req_wdata | input | 64 | Write data |
| stat_in | input | 64 | Interrupt status vector seen at index 0x15 |
| probe_addr | input | 64 | Address compared against the window base |
| rd_data | output | 64 | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| wr_err | output | 1 | One-cycle pulse after an illegal write |
| win_en | output | 1 | Base register enable bit |
| win_base | output | 30 | Base register address bits 49:20 |
| win_hit | output | 1 | Probe address falls in the enabled window |

## Verification
The assertions assume at most one request per cycle, with `req_write` and `req_mmio` meaningful only while `req_valid` is high. The stimulus tasks drive each request for exactly one cycle on the falling edge and then drop `req_valid`, so no request overlaps another. The properties that watch the base register assume that no scan write to index 0x0A occurs in the same cycle as a memory-mapped one. That always holds, because the channel carries a single request.

// File: rtl/svc_regbank.sv
module svc_regbank #(
  parameter int          IDX_W    = 5,
  parameter int          MM_OFS   = 10,
  parameter logic [63:0] RST_BASE = 64'h0003_FFFE_8000_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_mmio,
  input  logic [IDX_W-1:0] req_index,
  input  logic [63:0]      req_wdata,
  input  logic [63:0]      stat_in,
  input  logic [63:0]      probe_addr,
  output logic [63:0]      rd_data,
  output logic             rd_valid,
  output logic             wr_err,
  output logic             win_en,
  output logic [29:0]      win_base,
  output logic             win_hit
);
  localparam int EW = IDX_W + 1;
  localparam int HI = 49;
  localparam int LO = 20;

  localparam logic [63:0] BASE_KEEP  = 64'h0003_FFFF_FFF0_0001;
  localparam logic [63:0] SBASE_KEEP = 64'h0003_FFFF_0000_0000;

  localparam logic [EW-1:0] I_FLT   = EW'(8'h00);
  localparam logic [EW-1:0] I_FAND  = EW'(8'h01);
  localparam logic [EW-1:0] I_FOR   = EW'(8'h02);
  localparam logic [EW-1:0] I_ACT0  = EW'(8'h06);
  localparam logic [EW-1:0] I_ACT1  = EW'(8'h07);
  localparam logic [EW-1:0] I_BASE  = EW'(8'h0A);
  localparam logic [EW-1:0] I_SBASE = EW'(8'h0B);
  localparam logic [EW-1:0] I_CTL   = EW'(8'h0E);
  localparam logic [EW-1:0] I_EMSK  = EW'(8'h0F);
  localparam logic [EW-1:0] I_CSET  = EW'(8'h12);
  localparam logic [EW-1:0] I_CCLR  = EW'(8'h13);
  localparam logic [EW-1:0] I_DUP   = EW'(8'h14);
  localparam logic [EW-1:0] I_STAT  = EW'(8'h15);

  logic [63:0] fault_q, act0_q, act1_q, base_q, sbase_q, ctl_q, emsk_q, dup_q;
  logic [EW-1:0] eff;
  logic [63:0]   rmux;
  logic          wr, rd, illegal;

  assign eff = req_mmio ? (EW'(req_index) + EW'(MM_OFS)) : EW'(req_index);
  assign wr  = req_valid &  req_write;
  assign rd  = req_valid & ~req_write;
  assign illegal = wr & (((eff == I_BASE) & req_mmio) | (eff == I_STAT));

  always_comb begin
    case (eff)
      I_FLT:   rmux = fault_q;
      I_ACT0:  rmux = act0_q;
      I_ACT1:  rmux = act1_q;
      I_BASE:  rmux = base_q;
      I_SBASE: rmux = sbase_q;
      I_CTL:   rmux = ctl_q;
      I_EMSK:  rmux = emsk_q;
      I_DUP:   rmux = dup_q;
      I_STAT:  rmux = stat_in;
      default: rmux = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault_q <= '0;
      act0_q  <= '0;
      act1_q  <= '0;
      base_q  <= (RST_BASE & BASE_KEEP) | 64'd1;
      sbase_q <= '0;
      ctl_q   <= '0;
      emsk_q  <= '0;
      dup_q   <= '0;
    end else if (wr) begin
      case (eff)
        I_FLT:   fault_q <= req_wdata;
        I_FAND:  fault_q <= fault_q & req_wdata;
        I_FOR:   fault_q <= fault_q | req_wdata;
        I_ACT0:  act0_q  <= req_wdata;
        I_ACT1:  act1_q  <= req_wdata;
        I_BASE:  if (!req_mmio) base_q <= req_wdata & BASE_KEEP;
        I_SBASE: sbase_q <= req_wdata & SBASE_KEEP;
        I_CTL:   ctl_q   <= req_wdata;
        I_CSET:  ctl_q   <= ctl_q | req_wdata;
        I_CCLR:  ctl_q   <= ctl_q & ~req_wdata;
        I_EMSK:  emsk_q  <= req_wdata;
        I_DUP:   dup_q   <= req_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
      wr_err   <= 1'b0;
    end else begin
      rd_valid <= rd;
      wr_err   <= illegal;
      if (rd) rd_data <= rmux;
    end
  end

  assign win_en   = base_q[0];
  assign win_base = base_q[HI:LO];
  assign win_hit  = win_en & (probe_addr[HI:LO] == win_base);
endmodule

// File: rtl/svc_regbank_chk.sv
module svc_regbank_chk #(
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_write,
  input logic             req_mmio,
  input logic [IDX_W-1:0] req_index,
  input logic [63:0]      rd_data,
  input logic             rd_valid,
  input logic             wr_err,
  input logic             win_en,
  input logic [29:0]      win_base,
  input logic             win_hit
);
  a_r9_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rd_valid);

  a_r9_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rd_valid);

  a_r9_err_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write) |=> !wr_err);

  a_r4_mmio_base_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_mmio) |=> ($stable(win_base) && $stable(win_en)));

  a_r4_mmio_base_err: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_mmio && req_index == '0) |=> wr_err);

  a_r10_hit_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit |-> win_en);

  a_r7_alias_reads_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !req_mmio && req_index == IDX_W'(1)) |=> (rd_data == '1));
endmodule

bind svc_regbank svc_regbank_chk #(.IDX_W(IDX_W)) u_chk (.*);

// File: tb/sim_svc_regbank.sv
`timescale 1ns/1ps
module sim_svc_regbank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_mmio = 1'b0;
  logic [4:0]  req_index = '0;
  logic [63:0] req_wdata = '0, stat_in = '0, probe_addr = '0;
  logic [63:0] rd_data;
  logic        rd_valid, wr_err, win_en, win_hit;
  logic [29:0] win_base;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [63:0] rv;
  logic        ev;

  localparam logic [63:0] RB = 64'h0003_FFFE_8000_0000;
  localparam logic [63:0] ONES = '1;

  always #4 clk = ~clk;

  svc_regbank u0 (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic mm, input logic [4:0] idx, input logic [63:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_mmio = mm; req_index = idx; req_wdata = d;
    @(negedge clk);
    ev = wr_err;
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input logic mm, input logic [4:0] idx);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_mmio = mm; req_index = idx;
    @(negedge clk);
    rv = rd_data;
    chk("R9 rd_valid after read", 64'(rd_valid), 64'd1);
    req_valid = 0;
    @(negedge clk);
    chk("R9 rd_valid drops", 64'(rd_valid), 64'd0);
  endtask

  task automatic t_reset();
    chk("R8 rd_valid after reset", 64'(rd_valid), 0);
    chk("R8 wr_err after reset", 64'(wr_err), 0);
    chk("R8 win_en after reset", 64'(win_en), 1);
    chk("R8 win_base after reset", 64'(win_base), 64'(RB[49:20]));
    rd(0, 5'h0A); chk("R8 base reset value", rv, (RB & 64'h0003_FFFF_FFF0_0001) | 1);
    rd(0, 5'h00); chk("R8 fault reset zero", rv, 0);
    rd(0, 5'h0E); chk("R8 control reset zero", rv, 0);
  endtask

  task automatic t_map();
    rd(1, 5'h00); chk("R1 mmio word0 is base", rv, (RB & 64'h0003_FFFF_FFF0_0001) | 1);
    wr(0, 5'h0F, 64'hA5A5_0000_1111_2222);
    rd(1, 5'h05); chk("R1 mmio word5 is index 0x0F", rv, 64'hA5A5_0000_1111_2222);
    rd(1, 5'h16); chk("R1 mmio past top reads ones", rv, ONES);
  endtask

  task automatic t_fault();
    wr(0, 5'h00, 64'hF0F0_F0F0_F0F0_F0F0); chk("R2 plain write no err", 64'(ev), 0);
    wr(0, 5'h01, 64'hFF00_FF00_FF00_FF00);
    rd(0, 5'h00); chk("R2 AND alias", rv, 64'hF000_F000_F000_F000);
    wr(0, 5'h02, 64'h0000_0000_0000_000F);
    rd(0, 5'h00); chk("R2 OR alias", rv, 64'hF000_F000_F000_F00F);
  endtask

  task automatic t_ctl();
    wr(1, 5'h04, 64'h1000_0000_0000_0001);
    rd(0, 5'h0E); chk("R3 control via mmio", rv, 64'h1000_0000_0000_0001);
    wr(1, 5'h08, 64'h0400_8000_0000_0000);
    rd(0, 5'h0E); chk("R3 set alias", rv, 64'h1400_8000_0000_0001);
    wr(0, 5'h13, 64'h1000_0000_0000_0001);
    rd(0, 5'h0E); chk("R3 clear alias", rv, 64'h0400_8000_0000_0000);
  endtask

  task automatic t_base();
    wr(0, 5'h0A, ONES); chk("R4 scan write no err", 64'(ev), 0);
    rd(0, 5'h0A); chk("R4 base field mask", rv, 64'h0003_FFFF_FFF0_0001);
    wr(1, 5'h00, 64'h0000_1111_1110_0000); chk("R4 mmio base write error", 64'(ev), 1);
    @(negedge clk); chk("R9 error lasts one cycle", 64'(wr_err), 0);
    rd(0, 5'h0A); chk("R4 mmio base write dropped", rv, 64'h0003_FFFF_FFF0_0001);
  endtask

  task automatic t_sbase();
    wr(0, 5'h0B, ONES);
    rd(0, 5'h0B); chk("R5 secondary base mask", rv, 64'h0003_FFFF_0000_0000);
  endtask

  task automatic t_stat();
    stat_in = 64'h0000_0013_0000_0000;
    rd(0, 5'h15); chk("R6 status read", rv, 64'h0000_0013_0000_0000);
    wr(0, 5'h15, 64'h0); chk("R6 status write error", 64'(ev), 1);
    rd(1, 5'h0B); chk("R6 status after write via mmio", rv, 64'h0000_0013_0000_0000);
  endtask

  task automatic t_unimpl();
    rd(0, 5'h03); chk("R7 unimplemented read", rv, ONES);
    rd(0, 5'h12); chk("R7 set alias reads ones", rv, ONES);
    rd(0, 5'h01); chk("R7 AND alias reads ones", rv, ONES);
    wr(0, 5'h1F, 64'h1234); chk("R7 unimpl write no err", 64'(ev), 0);
    rd(0, 5'h1F); chk("R7 unimpl still ones", rv, ONES);
  endtask

  task automatic t_plain();
    wr(0, 5'h06, 64'hDEAD_BEEF_0123_4567);
    wr(0, 5'h07, 64'h8000_0000_0000_0001);
    wr(1, 5'h0A, 64'h5555_AAAA_5555_AAAA);
    rd(0, 5'h06); chk("R11 reg 0x06", rv, 64'hDEAD_BEEF_0123_4567);
    rd(0, 5'h07); chk("R11 reg 0x07", rv, 64'h8000_0000_0000_0001);
    rd(0, 5'h14); chk("R11 reg 0x14 via mmio word", rv, 64'h5555_AAAA_5555_AAAA);
  endtask

  task automatic t_window();
    wr(0, 5'h0A, 64'h0000_1234_5000_0001);
    probe_addr = 64'h0000_1234_500F_FFF8; #1;
    chk("R10 hit inside window", 64'(win_hit), 1);
    chk("R10 exported base", 64'(win_base), 64'(64'h0000_1234_5000_0000 >> 20));
    probe_addr = 64'h0000_1234_5010_0000; #1;
    chk("R10 miss next window", 64'(win_hit), 0);
    probe_addr = 64'h0000_1234_5000_0000;
    wr(0, 5'h0A, 64'h0000_1234_5000_0000);
    chk("R10 disabled no hit", 64'(win_hit), 0);
    chk("R10 enable exported low", 64'(win_en), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset(); t_map(); t_fault(); t_ctl(); t_base();
    t_sbase(); t_stat(); t_unimpl(); t_plain(); t_window();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule